// File: doc/BRIEF.md
# Sectored Line Dirty-Byte Tracker

This block keeps the bookkeeping state for a small, directly indexed group of sectored lines in a write-back data cache. Each line stores a tag, a state per sector (invalid, reserved by an outstanding fill, valid, modified), two per-sector flags that record a write arriving while a fill is pending, and a byte-granular dirty mask that grows by OR with every write. The data array, the replacement choice and the lower memory level live elsewhere. The caller names the victim line by index.

Requests enter on one valid/ready channel with an operation code, a line index, a tag, a sector mask and a byte-enable mask. When a line that holds modified sectors is reallocated or explicitly evicted, the block captures a writeback descriptor: the block address, the modified size, the accumulated byte mask and the mask of modified sectors. It presents the descriptor on a second valid/ready channel. Back-pressure rules: the descriptor stays stable while `wb_valid` is high and `wb_ready` is low. Any request that would produce a new descriptor holds `req_ready` low until the pending one is taken. Requests that produce no descriptor flow through. A transfer happens on a rising edge where valid and ready are both high.

Top module: `sct_tracker`

## Requirements
- R1: Operation codes are write=0, read-allocate=1, fill=2, evict=3. A write whose tag matches a valid line ORs its byte-enable mask into the line's dirty mask, so a later writeback carries the OR of every write since the line was allocated.
- R2: A writeback's sector mask has bit i set exactly for sectors in the modified state. Its size equals 32 times the number of set bits in that mask (128-byte line, four 32-byte sectors, byte i in sector i/32).
- R3: Reallocating a line to a new tag (write or read miss), or evicting it, clears its dirty mask, sector states and fill flags in the same cycle the victim record is latched. The new line starts only from the accepted request.
- R4: A read or write miss on a valid line with at least one modified sector produces a writeback for the old block, address = {old tag, index, 7'b0}, in the cycle after the request is accepted.
- R5: A write miss allocates the line without fetching: the requested sectors become modified, all others invalid, and the dirty mask equals the request's byte mask.
- R6: A read allocate marks the requested sectors reserved. A write that hits a reserved sector leaves it reserved and flags it. A fill with matching tag turns flagged reserved sectors into modified sectors and unflagged ones into valid (clean) sectors.
- R7: Evicting or replacing a line with no modified sector, including an invalid line or one whose sectors are only reserved or valid, produces no writeback.
- R8: While `cfg_write_through` is high, no writeback descriptor is produced.
- R9: While `wb_valid` is high and `wb_ready` is low, `wb_valid` and all descriptor fields stay unchanged.
- R10: While a writeback is pending, a request that would produce another one sees `req_ready` low. A request that produces none is accepted.
- R11: After reset every line is invalid, `wb_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_write_through | input | 1 | Suppress all writeback descriptors |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_op | input | 2 | 0 write, 1 read-allocate, 2 fill, 3 evict |
| req_idx | input | IDX_W (2) | Line index (victim for misses) |
| req_tag | input | TAG_W (23) | Block tag |
| req_smask | input | SECTORS (4) | Sectors touched |
| req_bmask | input | LINE_BYTES (128) | Byte enables of a write |
| wb_valid | output | 1 | Writeback descriptor present |
| wb_ready | input | 1 | Receiver takes the descriptor |
| wb_addr | output | ADDR_W (32) | Block address of the evicted line |
| wb_size | output | SIZE_W (8) | Modified size in bytes |
| wb_bmask | output | LINE_BYTES (128) | Accumulated dirty byte mask |
| wb_smask | output | SECTORS (4) | Modified sector mask |

## Verification
The dirty-mask path is driven with repeated hits on one line whose byte enables fall in separate sectors. This separates true OR accumulation from overwrite-by-last-write, and shows whether untouched sectors leak into the sector mask. Reallocation follows a dirty line with a miss to the same index and checks that the descriptor holds only the old line's bytes and that the new line's later writeback holds only its own. This exposes a missed clear. The reserved-sector pattern (read allocate, write into the pending sector, fill of two sectors) separates modified-on-fill sectors from plain valid ones. Back-pressure is tried with a held descriptor while a harmless request and then a dirty eviction arrive. Write-through mode is checked with an eviction that would otherwise produce a descriptor.

// File: rtl/sct_pkg.sv
package sct_pkg;

  typedef enum logic [1:0] {
    SEC_INVALID  = 2'd0,
    SEC_RESERVED = 2'd1,
    SEC_VALID    = 2'd2,
    SEC_MODIFIED = 2'd3
  } sec_state_e;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_READ  = 2'd1,
    OP_FILL  = 2'd2,
    OP_EVICT = 2'd3
  } op_e;

endpackage

// File: rtl/sct_line_store.sv
module sct_line_store #(
  parameter int LINES      = 4,
  parameter int SECTORS    = 4,
  parameter int LINE_BYTES = 128,
  parameter int TAG_W      = 23,
  localparam int IDX_W     = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int ST_W      = 2 * SECTORS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic                  rd_valid,
  output logic [TAG_W-1:0]      rd_tag,
  output logic [ST_W-1:0]       rd_st,
  output logic [LINE_BYTES-1:0] rd_bmask,
  output logic [SECTORS-1:0]    rd_mof,
  output logic [SECTORS-1:0]    rd_iof,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic                  wr_valid,
  input  logic [TAG_W-1:0]      wr_tag,
  input  logic [ST_W-1:0]       wr_st,
  input  logic [LINE_BYTES-1:0] wr_bmask,
  input  logic [SECTORS-1:0]    wr_mof,
  input  logic [SECTORS-1:0]    wr_iof
);

  logic                  lv  [LINES];
  logic [TAG_W-1:0]      lt  [LINES];
  logic [ST_W-1:0]       ls  [LINES];
  logic [LINE_BYTES-1:0] lb  [LINES];
  logic [SECTORS-1:0]    lm  [LINES];
  logic [SECTORS-1:0]    li  [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic                  valid_q;
    logic [TAG_W-1:0]      tag_q;
    logic [ST_W-1:0]       st_q;
    logic [LINE_BYTES-1:0] bmask_q;
    logic [SECTORS-1:0]    mof_q;
    logic [SECTORS-1:0]    iof_q;
    logic                  sel;

    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= 1'b0;
        tag_q   <= '0;
        st_q    <= '0;
        bmask_q <= '0;
        mof_q   <= '0;
        iof_q   <= '0;
      end else if (sel) begin
        valid_q <= wr_valid;
        tag_q   <= wr_tag;
        st_q    <= wr_st;
        bmask_q <= wr_bmask;
        mof_q   <= wr_mof;
        iof_q   <= wr_iof;
      end
    end

    assign lv[g] = valid_q;
    assign lt[g] = tag_q;
    assign ls[g] = st_q;
    assign lb[g] = bmask_q;
    assign lm[g] = mof_q;
    assign li[g] = iof_q;
  end

  assign rd_valid = lv[rd_idx];
  assign rd_tag   = lt[rd_idx];
  assign rd_st    = ls[rd_idx];
  assign rd_bmask = lb[rd_idx];
  assign rd_mof   = lm[rd_idx];
  assign rd_iof   = li[rd_idx];

  // An invalid line holds no modified sector (supports R7/R11).
  p_invalid_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_valid) |=> (lb[$past(wr_idx)] == '0));

endmodule

// File: rtl/sct_line_next.sv
module sct_line_next
  import sct_pkg::*;
#(
  parameter int SECTORS    = 4,
  parameter int LINE_BYTES = 128,
  parameter int TAG_W      = 23,
  localparam int ST_W      = 2 * SECTORS,
  localparam int SEC_BYTES = LINE_BYTES / SECTORS,
  localparam int SIZE_W    = $clog2(LINE_BYTES + 1)
) (
  input  op_e                   op,
  input  logic [TAG_W-1:0]      req_tag,
  input  logic [SECTORS-1:0]    req_smask,
  input  logic [LINE_BYTES-1:0] req_bmask,
  input  logic                  cur_valid,
  input  logic [TAG_W-1:0]      cur_tag,
  input  logic [ST_W-1:0]       cur_st,
  input  logic [LINE_BYTES-1:0] cur_bmask,
  input  logic [SECTORS-1:0]    cur_mof,
  input  logic [SECTORS-1:0]    cur_iof,
  output logic                  nxt_valid,
  output logic [TAG_W-1:0]      nxt_tag,
  output logic [ST_W-1:0]       nxt_st,
  output logic [LINE_BYTES-1:0] nxt_bmask,
  output logic [SECTORS-1:0]    nxt_mof,
  output logic [SECTORS-1:0]    nxt_iof,
  output logic                  vic_dirty,
  output logic [SECTORS-1:0]    vic_smask,
  output logic [SIZE_W-1:0]     vic_size
);

  sec_state_e          cur_se [SECTORS];
  logic [SECTORS-1:0]  mod_vec;
  logic                hit;
  logic                replace;

  always_comb begin
    for (int i = 0; i < SECTORS; i++) begin
      cur_se[i]  = sec_state_e'(cur_st[2*i +: 2]);
      mod_vec[i] = (cur_se[i] == SEC_MODIFIED);
    end
  end

  assign hit     = cur_valid && (cur_tag == req_tag);
  assign replace = ((op == OP_WRITE) || (op == OP_READ)) && !hit;

  always_comb begin
    vic_dirty = cur_valid && (|mod_vec) && (replace || (op == OP_EVICT));
    vic_smask = mod_vec;
    vic_size  = '0;
    for (int i = 0; i < SECTORS; i++) begin
      if (mod_vec[i]) vic_size = vic_size + SIZE_W'(SEC_BYTES);
    end
  end

  always_comb begin
    nxt_valid = cur_valid;
    nxt_tag   = cur_tag;
    nxt_st    = cur_st;
    nxt_bmask = cur_bmask;
    nxt_mof   = cur_mof;
    nxt_iof   = cur_iof;
    unique case (op)
      OP_WRITE: begin
        if (hit) begin
          for (int i = 0; i < SECTORS; i++) begin
            if (req_smask[i]) begin
              if (cur_se[i] == SEC_RESERVED) begin
                nxt_mof[i] = 1'b1;
                nxt_iof[i] = 1'b1;
              end else begin
                nxt_st[2*i +: 2] = SEC_MODIFIED;
              end
            end
          end
          nxt_bmask = cur_bmask | req_bmask;
        end else begin
          nxt_valid = 1'b1;
          nxt_tag   = req_tag;
          nxt_mof   = '0;
          nxt_iof   = '0;
          nxt_bmask = req_bmask;
          for (int i = 0; i < SECTORS; i++) begin
            nxt_st[2*i +: 2] = req_smask[i] ? SEC_MODIFIED : SEC_INVALID;
          end
        end
      end
      OP_READ: begin
        if (hit) begin
          for (int i = 0; i < SECTORS; i++) begin
            if (req_smask[i] && (cur_se[i] == SEC_INVALID))
              nxt_st[2*i +: 2] = SEC_RESERVED;
          end
        end else begin
          nxt_valid = 1'b1;
          nxt_tag   = req_tag;
          nxt_mof   = '0;
          nxt_iof   = '0;
          nxt_bmask = '0;
          for (int i = 0; i < SECTORS; i++) begin
            nxt_st[2*i +: 2] = req_smask[i] ? SEC_RESERVED : SEC_INVALID;
          end
        end
      end
      OP_FILL: begin
        if (hit) begin
          for (int i = 0; i < SECTORS; i++) begin
            if (req_smask[i] && (cur_se[i] == SEC_RESERVED)) begin
              nxt_st[2*i +: 2] = cur_mof[i] ? SEC_MODIFIED : SEC_VALID;
              nxt_mof[i] = 1'b0;
              nxt_iof[i] = 1'b0;
            end
          end
        end
      end
      default: begin
        nxt_valid = 1'b0;
        nxt_st    = '0;
        nxt_bmask = '0;
        nxt_mof   = '0;
        nxt_iof   = '0;
      end
    endcase
  end

endmodule

// File: rtl/sct_wb_slot.sv
module sct_wb_slot #(
  parameter int ADDR_W     = 32,
  parameter int SECTORS    = 4,
  parameter int LINE_BYTES = 128,
  localparam int SEC_BYTES = LINE_BYTES / SECTORS,
  localparam int SIZE_W    = $clog2(LINE_BYTES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push,
  input  logic [ADDR_W-1:0]     push_addr,
  input  logic [SIZE_W-1:0]     push_size,
  input  logic [LINE_BYTES-1:0] push_bmask,
  input  logic [SECTORS-1:0]    push_smask,
  output logic                  wb_valid,
  input  logic                  wb_ready,
  output logic [ADDR_W-1:0]     wb_addr,
  output logic [SIZE_W-1:0]     wb_size,
  output logic [LINE_BYTES-1:0] wb_bmask,
  output logic [SECTORS-1:0]    wb_smask
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_addr  <= '0;
      wb_size  <= '0;
      wb_bmask <= '0;
      wb_smask <= '0;
    end else begin
      if (push) begin
        wb_valid <= 1'b1;
        wb_addr  <= push_addr;
        wb_size  <= push_size;
        wb_bmask <= push_bmask;
        wb_smask <= push_smask;
      end else if (wb_ready) begin
        wb_valid <= 1'b0;
      end
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_size)
                                 && $stable(wb_bmask) && $stable(wb_smask)));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !wb_valid);

  p_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_size == SIZE_W'(SEC_BYTES * $countones(wb_smask))));

  p_dirty_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_smask != '0));

endmodule

// File: rtl/sct_tracker.sv
module sct_tracker
  import sct_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINES      = 4,
  parameter int LINE_BYTES = 128,
  parameter int SECTORS    = 4,
  localparam int IDX_W     = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int TAG_W     = ADDR_W - IDX_W - OFF_W,
  localparam int ST_W      = 2 * SECTORS,
  localparam int SIZE_W    = $clog2(LINE_BYTES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_write_through,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [1:0]            req_op,
  input  logic [IDX_W-1:0]      req_idx,
  input  logic [TAG_W-1:0]      req_tag,
  input  logic [SECTORS-1:0]    req_smask,
  input  logic [LINE_BYTES-1:0] req_bmask,
  output logic                  wb_valid,
  input  logic                  wb_ready,
  output logic [ADDR_W-1:0]     wb_addr,
  output logic [SIZE_W-1:0]     wb_size,
  output logic [LINE_BYTES-1:0] wb_bmask,
  output logic [SECTORS-1:0]    wb_smask
);

  logic                  cur_valid;
  logic [TAG_W-1:0]      cur_tag;
  logic [ST_W-1:0]       cur_st;
  logic [LINE_BYTES-1:0] cur_bmask;
  logic [SECTORS-1:0]    cur_mof, cur_iof;
  logic                  nxt_valid;
  logic [TAG_W-1:0]      nxt_tag;
  logic [ST_W-1:0]       nxt_st;
  logic [LINE_BYTES-1:0] nxt_bmask;
  logic [SECTORS-1:0]    nxt_mof, nxt_iof;
  logic                  vic_dirty;
  logic [SECTORS-1:0]    vic_smask;
  logic [SIZE_W-1:0]     vic_size;
  logic                  need_wb, accept, push;
  logic [ADDR_W-1:0]     vic_addr;

  sct_line_store #(
    .LINES(LINES), .SECTORS(SECTORS), .LINE_BYTES(LINE_BYTES), .TAG_W(TAG_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(req_idx), .rd_valid(cur_valid), .rd_tag(cur_tag), .rd_st(cur_st),
    .rd_bmask(cur_bmask), .rd_mof(cur_mof), .rd_iof(cur_iof),
    .wr_en(accept), .wr_idx(req_idx), .wr_valid(nxt_valid), .wr_tag(nxt_tag),
    .wr_st(nxt_st), .wr_bmask(nxt_bmask), .wr_mof(nxt_mof), .wr_iof(nxt_iof)
  );

  sct_line_next #(
    .SECTORS(SECTORS), .LINE_BYTES(LINE_BYTES), .TAG_W(TAG_W)
  ) u_next (
    .op(op_e'(req_op)), .req_tag(req_tag), .req_smask(req_smask), .req_bmask(req_bmask),
    .cur_valid(cur_valid), .cur_tag(cur_tag), .cur_st(cur_st), .cur_bmask(cur_bmask),
    .cur_mof(cur_mof), .cur_iof(cur_iof),
    .nxt_valid(nxt_valid), .nxt_tag(nxt_tag), .nxt_st(nxt_st), .nxt_bmask(nxt_bmask),
    .nxt_mof(nxt_mof), .nxt_iof(nxt_iof),
    .vic_dirty(vic_dirty), .vic_smask(vic_smask), .vic_size(vic_size)
  );

  assign need_wb   = vic_dirty && !cfg_write_through;
  assign req_ready = !(need_wb && wb_valid);
  assign accept    = req_valid && req_ready;
  assign push      = accept && need_wb;
  assign vic_addr  = {cur_tag, req_idx, {OFF_W{1'b0}}};

  sct_wb_slot #(
    .ADDR_W(ADDR_W), .SECTORS(SECTORS), .LINE_BYTES(LINE_BYTES)
  ) u_wb (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_addr(vic_addr), .push_size(vic_size),
    .push_bmask(cur_bmask), .push_smask(vic_smask),
    .wb_valid(wb_valid), .wb_ready(wb_ready),
    .wb_addr(wb_addr), .wb_size(wb_size), .wb_bmask(wb_bmask), .wb_smask(wb_smask)
  );

  p_wt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_write_through && !wb_valid) |=> !wb_valid);

endmodule

// File: tb/sct_tracker_tb.sv
`timescale 1ns/1ps
module sct_tracker_tb;

  localparam int CLK_NS = 5;
  localparam int TAG_W  = 23;

  typedef struct packed {
    logic [1:0]   op;
    logic [1:0]   idx;
    logic [7:0]   tag;
    logic [3:0]   smask;
    logic [127:0] bmask;
    logic         exp_wb;
    logic [31:0]  exp_addr;
    logic [7:0]   exp_size;
    logic [3:0]   exp_smask;
    logic [127:0] exp_bmask;
  } vec_t;

  localparam logic [127:0] ONES = {128{1'b1}};

  localparam vec_t VEC [13] = '{
    '{2'd0, 2'd0, 8'd5, 4'h1, 128'hF,         1'b0, 32'h0,    8'd0,   4'h0, 128'h0},
    '{2'd0, 2'd0, 8'd5, 4'h1, 128'hF0,        1'b0, 32'h0,    8'd0,   4'h0, 128'h0},
    '{2'd0, 2'd0, 8'd5, 4'h4, 128'hF << 64,   1'b0, 32'h0,    8'd0,   4'h0, 128'h0},
    '{2'd3, 2'd0, 8'd0, 4'h0, 128'h0,         1'b1, 32'hA00,  8'd64,  4'h5, (128'hF << 64) | 128'hFF},
    '{2'd3, 2'd0, 8'd0, 4'h0, 128'h0,         1'b0, 32'h0,    8'd0,   4'h0, 128'h0},
    '{2'd1, 2'd1, 8'd3, 4'h3, 128'h0,         1'b0, 32'h0,    8'd0,   4'h0, 128'h0},
    '{2'd0, 2'd1, 8'd3, 4'h2, 128'hFF << 32,  1'b0, 32'h0,    8'd0,   4'h0, 128'h0},
    '{2'd2, 2'd1, 8'd3, 4'h3, 128'h0,         1'b0, 32'h0,    8'd0,   4'h0, 128'h0},
    '{2'd0, 2'd1, 8'd9, 4'h8, 128'h1 << 127,  1'b1, 32'h680,  8'd32,  4'h2, 128'hFF << 32},
    '{2'd1, 2'd1, 8'd4, 4'h1, 128'h0,         1'b1, 32'h1280, 8'd32,  4'h8, 128'h1 << 127},
    '{2'd3, 2'd1, 8'd0, 4'h0, 128'h0,         1'b0, 32'h0,    8'd0,   4'h0, 128'h0},
    '{2'd0, 2'd2, 8'd1, 4'hF, ONES,           1'b0, 32'h0,    8'd0,   4'h0, 128'h0},
    '{2'd3, 2'd2, 8'd0, 4'h0, 128'h0,         1'b1, 32'h300,  8'd128, 4'hF, ONES}
  };

  // Requirement exercised by each row.
  localparam string VEC_REQ [13] = '{
    "R5", "R1", "R1", "R2", "R7", "R6", "R6", "R6", "R4", "R3", "R7", "R5", "R2"
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_write_through = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [1:0]   req_op = '0;
  logic [1:0]   req_idx = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic [3:0]   req_smask = '0;
  logic [127:0] req_bmask = '0;
  logic         wb_valid;
  logic         wb_ready = 1'b0;
  logic [31:0]  wb_addr;
  logic [7:0]   wb_size;
  logic [127:0] wb_bmask;
  logic [3:0]   wb_smask;

  int total = 0;
  int bad = 0;

  always #(CLK_NS / 2.0) clk = ~clk;

  sct_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_write_through(cfg_write_through),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_idx(req_idx), .req_tag(req_tag), .req_smask(req_smask), .req_bmask(req_bmask),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_size(wb_size),
    .wb_bmask(wb_bmask), .wb_smask(wb_smask)
  );

  task automatic chk(input string rq, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Drive one request from a negedge, wait until it is accepted.
  task automatic issue(input logic [1:0] op, input logic [1:0] idx, input logic [7:0] tag,
                       input logic [3:0] sm, input logic [127:0] bm);
    req_op    = op;
    req_idx   = idx;
    req_tag   = TAG_W'(tag);
    req_smask = sm;
    req_bmask = bm;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    if (wb_valid) begin
      wb_ready = 1'b1;
      @(negedge clk);
      wb_ready = 1'b0;
    end
  endtask

  initial begin
    #(CLK_NS * 100000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state
    chk("R11", "wb_valid after reset", 128'(wb_valid), 128'd0);
    chk("R11", "req_ready after reset", 128'(req_ready), 128'd1);
    issue(2'd3, 2'd3, 8'd0, 4'h0, 128'h0);
    chk("R11", "evict of untouched line", 128'(wb_valid), 128'd0);

    // Table walk
    for (int k = 0; k < 13; k++) begin
      issue(VEC[k].op, VEC[k].idx, VEC[k].tag, VEC[k].smask, VEC[k].bmask);
      chk(VEC_REQ[k], $sformatf("row %0d wb_valid", k), 128'(wb_valid), 128'(VEC[k].exp_wb));
      if (VEC[k].exp_wb) begin
        chk(VEC_REQ[k], $sformatf("row %0d addr", k),  128'(wb_addr),  128'(VEC[k].exp_addr));
        chk(VEC_REQ[k], $sformatf("row %0d size", k),  128'(wb_size),  128'(VEC[k].exp_size));
        chk(VEC_REQ[k], $sformatf("row %0d smask", k), 128'(wb_smask), 128'(VEC[k].exp_smask));
        chk(VEC_REQ[k], $sformatf("row %0d bmask", k), wb_bmask,       VEC[k].exp_bmask);
      end
      drain();
    end

    // R9 / R10: back-pressure
    issue(2'd0, 2'd3, 8'd1, 4'h1, 128'h1);
    issue(2'd0, 2'd2, 8'd1, 4'h1, 128'h2);
    issue(2'd3, 2'd3, 8'd0, 4'h0, 128'h0);
    chk("R9", "pending wb_valid", 128'(wb_valid), 128'd1);
    repeat (3) @(negedge clk);
    chk("R9", "held wb_valid", 128'(wb_valid), 128'd1);
    chk("R9", "held addr", 128'(wb_addr), 128'h380);
    chk("R9", "held bmask", wb_bmask, 128'h1);
    // harmless request while pending
    req_op = 2'd0; req_idx = 2'd0; req_tag = TAG_W'(2); req_smask = 4'h1;
    req_bmask = 128'h1; req_valid = 1'b1;
    #1;
    chk("R10", "ready for clean request", 128'(req_ready), 128'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10", "clean request made no wb", 128'(wb_addr), 128'h380);
    // dirty replacement while pending
    req_op = 2'd0; req_idx = 2'd2; req_tag = TAG_W'(7); req_smask = 4'h2;
    req_bmask = 128'h4; req_valid = 1'b1;
    #1;
    chk("R10", "stall dirty replacement", 128'(req_ready), 128'd0);
    wb_ready = 1'b1;
    @(negedge clk);
    wb_ready = 1'b0;
    chk("R10", "first wb taken", 128'(wb_valid), 128'd0);
    chk("R10", "ready after drain", 128'(req_ready), 128'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R4", "stalled wb valid", 128'(wb_valid), 128'd1);
    chk("R4", "stalled wb addr", 128'(wb_addr), 128'h300);
    chk("R3", "stalled wb bmask", wb_bmask, 128'h2);
    chk("R2", "stalled wb size", 128'(wb_size), 128'd32);
    drain();

    // R8: write-through suppresses writeback of dirty line idx0 tag2
    cfg_write_through = 1'b1;
    issue(2'd0, 2'd0, 8'd2, 4'h2, 128'h100);
    issue(2'd3, 2'd0, 8'd0, 4'h0, 128'h0);
    chk("R8", "no wb in write-through", 128'(wb_valid), 128'd0);
    cfg_write_through = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule